// File: doc/BRIEF.md
# UART Programmer Register Bank

This block is the register file that software sees on a UART peripheral. It sits on a simple synchronous bus and answers in the same cycle as the access. Each access carries a select, a write/read flag, a byte offset, an access-size code and 16-bit write data. The bank holds the divisor pair, global control, line control, modem control and scratch registers. Interrupt enables are changed only through two addresses: one that sets bits and one that clears them. Sticky error flags clear when a one is written to them. The ready bits of the line status word are taken live from the transmitter and receiver on every read.

The serial shifter, baud generator, FIFOs and DMA all sit outside this block. They connect through a few wires. A write to the transmit-holding address produces a one-cycle byte strobe toward the transmitter. A read of the receive-buffer address produces a one-cycle pop strobe and returns the receiver's current byte. Status events come in as single-cycle pulses, and the ready levels come in as plain signals.

Neither the byte strobe nor the pop strobe has back-pressure. The transmitter must take the byte in the cycle it is offered, and the receiver must present valid data whenever it is popped. The bus has no wait states. An access that breaks the size or address rules completes in one cycle with an error flag and a reason code, and it has no effect on any state.

Top module: `uart_regbank`

## Requirements
- R1: Registers lie at a 4-byte stride, by byte offset:
  - 0x00 divisor low and 0x04 divisor high.
  - 0x08 global control and 0x0C line control.
  - 0x10 modem control and 0x14 line status.
  - 0x18 modem status and 0x1C scratch.
  - 0x20 enable-set and 0x24 enable-clear.
  - 0x28 transmit holding and 0x2C receive buffer.
  - Divisor low, divisor high, global control, line control, modem control and scratch store all 16 written bits and read them back.
- R2: Only access size code 1 (16-bit) is legal. Any other size gives `bus_err`=1 with `bus_err_code`=1, even when the offset is also bad.
- R3: A legal size with an offset that is not 4-byte aligned, or that lies at 0x30 or above, gives `bus_err`=1 with `bus_err_code`=2. It changes no register and raises no strobe.
- R4: A write to enable-set ORs the write data into the 16-bit interrupt-enable register. A write to enable-clear clears every enable bit written as one.
- R5: A read of either enable-set or enable-clear returns the current interrupt-enable value.
- R6: Line status error flags and how they clear:
  - Flag bits are OE=1, PE=2, FE=3, BI=4 and TFI=7.
  - Each flag is set by its pulse on `stat_evt`, whose bits are 0=OE, 1=PE, 2=FE, 3=BI and 4=TFI.
  - A write clears each flag written as one and leaves all other bits alone.
  - When a set pulse and a clear hit the same flag in the same cycle, the flag stays set.
- R7: Modem status bit 0 is sticky and is set by `cts_evt`. A write with bit 0 at one clears it, and a set in the same cycle wins. All other modem status bits read zero.
- R8: A write to the receive-buffer address is ignored. It raises no pop and changes no state.
- R9: A line status read returns the live `live_dr` in bit 0, `live_thre` in bit 5 and `live_temt` in bit 6. Bits 15:8 read zero.
- R10: A write to transmit holding raises `tx_valid` in that cycle with `tx_data` equal to write data bits 7:0. It raises `tx_event` in the same cycle when interrupt-enable bit 1 is set. A later read of this address returns that byte zero-extended.
- R11: A read of the receive-buffer address raises `rx_pop` in that cycle and returns `rx_data` zero-extended.
- R12: After reset, divisor low reads 0x0001. All other stored registers, the interrupt enables and the error flags read zero.
- R13: `bus_err` is high only in the cycle of a bad access. Read data is zero for errored accesses, for writes and when no access is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from the block base |
| bus_size | input | 2 | Access size code (1 = 16-bit) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle |
| bus_err | output | 1 | Access rejected |
| bus_err_code | output | 2 | 0 none, 1 size, 2 address |
| tx_valid | output | 1 | Byte strobe toward transmitter |
| tx_data | output | 8 | Byte for transmitter |
| tx_event | output | 1 | Transmit event (enable bit 1 set) |
| rx_pop | output | 1 | Receive byte consumed |
| rx_data | input | 8 | Current received byte |
| live_dr | input | 1 | Receiver holds data |
| live_thre | input | 1 | Transmit holding empty |
| live_temt | input | 1 | Transmitter idle |
| stat_evt | input | 5 | Error flag set pulses {TFI,BI,FE,PE,OE} |
| cts_evt | input | 1 | Clear-to-send change pulse |

## Verification
The collision that matters is a status event pulse arriving in the same cycle as a software write-one-to-clear of that same flag, for both line and modem status. The bench forces this by driving `stat_evt` or `cts_evt` together with the clearing write. It then reads the register back and expects the flag still set. A second overlap, a transmit-holding write in the cycle after an enable-set, shows that the event gate uses the enable value already registered. A reference model updates in clear-then-set order and is compared on every clock, including during a long randomized mix of accesses and pulses.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int REG_COUNT = 12;
  localparam int PLAIN_N   = 6;

  typedef enum logic [3:0] {
    IDX_DIVLO     = 4'd0,
    IDX_DIVHI     = 4'd1,
    IDX_GCTRL     = 4'd2,
    IDX_LINECTL   = 4'd3,
    IDX_MODEMCTL  = 4'd4,
    IDX_LINESTAT  = 4'd5,
    IDX_MODEMSTAT = 4'd6,
    IDX_SCRATCH   = 4'd7,
    IDX_IENSET    = 4'd8,
    IDX_IENCLR    = 4'd9,
    IDX_TXHOLD    = 4'd10,
    IDX_RXBUF     = 4'd11
  } reg_idx_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SIZE = 2'd1,
    ERR_ADDR = 2'd2
  } err_code_e;

  localparam logic [1:0] SIZE_HALF = 2'd1;

  // line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_PE   = 2;
  localparam int LS_FE   = 3;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LS_TFI  = 7;
  localparam int MS_SCTS = 0;
  localparam int IE_TXEV = 1;

  // map plain storage slot to its register index
  function automatic int plain_slot(input int s);
    return (s == PLAIN_N - 1) ? int'(IDX_SCRATCH) : s;
  endfunction
endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output reg_idx_e          idx,
  output logic [REG_COUNT-1:0] hit_vec,
  output err_code_e         code
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] word_idx;
  logic          size_ok;
  logic          addr_ok;

  assign word_idx = addr[ADDR_W-1:2];
  assign size_ok  = (size == SIZE_HALF);
  assign addr_ok  = (addr[1:0] == 2'b00) && (word_idx < IW'(REG_COUNT));
  assign hit      = sel && size_ok && addr_ok;
  assign idx      = reg_idx_e'(word_idx[3:0]);

  // size fault outranks address fault
  always_comb begin
    code = ERR_NONE;
    if (sel && !size_ok)      code = ERR_SIZE;
    else if (sel && !addr_ok) code = ERR_ADDR;
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_hit
    assign hit_vec[g] = hit && (word_idx == IW'(g));
  end
endmodule

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_COUNT-1:0] hit_vec,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    plain_q [PLAIN_N],
  output logic [DATA_W-1:0]    ier_q,
  output logic [7:0]           thr_q
);
  logic unused_hits;
  assign unused_hits = ^{hit_vec[IDX_LINESTAT], hit_vec[IDX_MODEMSTAT], hit_vec[IDX_RXBUF]};

  for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
    localparam int SLOT = plain_slot(g);
    localparam logic [DATA_W-1:0] RST = (SLOT == int'(IDX_DIVLO)) ? DATA_W'(1) : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      plain_q[g] <= RST;
      else if (wr_en && hit_vec[SLOT]) plain_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
    end else if (wr_en && hit_vec[IDX_IENSET]) begin
      ier_q <= ier_q | wdata;
    end else if (wr_en && hit_vec[IDX_IENCLR]) begin
      ier_q <= ier_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             thr_q <= '0;
    else if (wr_en && hit_vec[IDX_TXHOLD])  thr_q <= wdata[7:0];
  end

  // R4: set then clear behave as OR and AND-NOT
  assert_ier_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_vec[IDX_IENSET]) |=> ((ier_q & $past(wdata)) == $past(wdata)));
  assert_ier_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_vec[IDX_IENCLR]) |=> ((ier_q & $past(wdata)) == '0));
endmodule

// File: rtl/uart_regbank_status.sv
module uart_regbank_status
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lsr,
  input  logic              wr_msr,
  input  logic [7:0]        wbyte,
  input  logic [4:0]        stat_evt,
  input  logic              cts_evt,
  input  logic              live_dr,
  input  logic              live_thre,
  input  logic              live_temt,
  output logic [DATA_W-1:0] lsr_word,
  output logic [DATA_W-1:0] msr_word
);
  logic [4:0] flags_q;  // {TFI,BI,FE,PE,OE}
  logic [4:0] clr_mask;
  logic       scts_q;
  logic       unused_wbits;

  assign unused_wbits = ^{wbyte[LS_THRE], wbyte[LS_TEMT]};
  assign clr_mask = wr_lsr ? {wbyte[LS_TFI], wbyte[LS_BI], wbyte[LS_FE], wbyte[LS_PE], wbyte[LS_OE]}
                           : 5'b0;

  // clear first, then set: a simultaneous event keeps the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | stat_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          scts_q <= 1'b0;
    else if (cts_evt)                    scts_q <= 1'b1;
    else if (wr_msr && wbyte[MS_SCTS])   scts_q <= 1'b0;
  end

  always_comb begin
    lsr_word          = '0;
    lsr_word[LS_DR]   = live_dr;
    lsr_word[LS_OE]   = flags_q[0];
    lsr_word[LS_PE]   = flags_q[1];
    lsr_word[LS_FE]   = flags_q[2];
    lsr_word[LS_BI]   = flags_q[3];
    lsr_word[LS_THRE] = live_thre;
    lsr_word[LS_TEMT] = live_temt;
    lsr_word[LS_TFI]  = flags_q[4];
    msr_word          = '0;
    msr_word[MS_SCTS] = scts_q;
  end

  // R6: an event pulse always leaves its flag set
  assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_evt) |=> ((flags_q & $past(stat_evt)) == $past(stat_evt)));
  // R6: a one written without a colliding event clears the OE flag
  assert_w1c_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lsr && wbyte[LS_OE] && !stat_evt[0]) |=> !flags_q[0]);
  // R7: the change event wins over a clear
  assert_cts_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cts_evt |=> scts_q);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [1:0]        bus_err_code,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_event,
  output logic              rx_pop,
  input  logic [7:0]        rx_data,
  input  logic              live_dr,
  input  logic              live_thre,
  input  logic              live_temt,
  input  logic [4:0]        stat_evt,
  input  logic              cts_evt
);
  logic                 hit;
  reg_idx_e             idx;
  logic [REG_COUNT-1:0] hit_vec;
  err_code_e            code;
  logic                 wr_en;
  logic [DATA_W-1:0]    plain_q [PLAIN_N];
  logic [DATA_W-1:0]    ier_q;
  logic [7:0]           thr_q;
  logic [DATA_W-1:0]    lsr_word;
  logic [DATA_W-1:0]    msr_word;

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .addr(bus_addr), .size(bus_size),
    .hit(hit), .idx(idx), .hit_vec(hit_vec), .code(code)
  );

  assign wr_en = hit && bus_we;

  uart_regbank_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_vec(hit_vec),
    .wdata(bus_wdata), .plain_q(plain_q), .ier_q(ier_q), .thr_q(thr_q)
  );

  uart_regbank_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .wr_lsr(wr_en && hit_vec[IDX_LINESTAT]),
    .wr_msr(wr_en && hit_vec[IDX_MODEMSTAT]),
    .wbyte(bus_wdata[7:0]), .stat_evt(stat_evt), .cts_evt(cts_evt),
    .live_dr(live_dr), .live_thre(live_thre), .live_temt(live_temt),
    .lsr_word(lsr_word), .msr_word(msr_word)
  );

  assign bus_err      = (code != ERR_NONE);
  assign bus_err_code = code;
  assign tx_valid     = wr_en && hit_vec[IDX_TXHOLD];
  assign tx_data      = bus_wdata[7:0];
  assign tx_event     = tx_valid && ier_q[IE_TXEV];
  assign rx_pop       = hit && !bus_we && hit_vec[IDX_RXBUF];

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_we) begin
      unique case (idx)
        IDX_DIVLO:     bus_rdata = plain_q[0];
        IDX_DIVHI:     bus_rdata = plain_q[1];
        IDX_GCTRL:     bus_rdata = plain_q[2];
        IDX_LINECTL:   bus_rdata = plain_q[3];
        IDX_MODEMCTL:  bus_rdata = plain_q[4];
        IDX_SCRATCH:   bus_rdata = plain_q[PLAIN_N-1];
        IDX_LINESTAT:  bus_rdata = lsr_word;
        IDX_MODEMSTAT: bus_rdata = msr_word;
        IDX_IENSET,
        IDX_IENCLR:    bus_rdata = ier_q;
        IDX_TXHOLD:    bus_rdata = DATA_W'(thr_q);
        IDX_RXBUF:     bus_rdata = DATA_W'(rx_data);
        default:       bus_rdata = '0;
      endcase
    end
  end

  // R2: a size fault is reported as such regardless of offset
  assert_size_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != SIZE_HALF) |-> (bus_err && bus_err_code == 2'd1));
  // R3 / R13: a rejected access is silent
  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!tx_valid && !rx_pop && bus_rdata == '0));
  assert_err_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (ier_q == $past(ier_q) && thr_q == $past(thr_q)
                 && plain_q[PLAIN_N-1] == $past(plain_q[PLAIN_N-1])));
  // R8: a write at the receive buffer never pops
  assert_rx_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |-> !rx_pop);
  // R10: the event needs both the byte strobe and the registered enable
  assert_tx_event_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_event |-> (tx_valid && ier_q[IE_TXEV]));
endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [1:0]  bus_err_code;
  logic        tx_valid, tx_event, rx_pop;
  logic [7:0]  tx_data;
  logic [7:0]  rx_data = 8'h00;
  logic        live_dr = 1'b0, live_thre = 1'b1, live_temt = 1'b1;
  logic [4:0]  stat_evt = '0;
  logic        cts_evt = 1'b0;

  always #10 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_err_code(bus_err_code),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_event(tx_event),
    .rx_pop(rx_pop), .rx_data(rx_data), .live_dr(live_dr),
    .live_thre(live_thre), .live_temt(live_temt),
    .stat_evt(stat_evt), .cts_evt(cts_evt)
  );

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  logic [15:0] m_reg [12];
  logic [15:0] m_ier;
  logic [7:0]  m_thr;
  logic [4:0]  m_flag;
  logic        m_scts;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 12; i++) m_reg[i] = 16'h0;
    m_reg[0] = 16'h0001;
    m_ier = '0; m_thr = '0; m_flag = '0; m_scts = 1'b0;
  endtask

  // one bus cycle: drive at negedge, compare before posedge, update model at posedge
  task automatic step(input logic sel, input logic we, input logic [5:0] addr,
                      input logic [1:0] size, input logic [15:0] wd,
                      input logic [4:0] evt, input logic cts, input string tag_in);
    int idx;
    logic sz_ok, ad_ok, hit;
    logic [15:0] e_rd;
    logic [1:0] e_code;
    string tag;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_size = size;
    bus_wdata = wd; stat_evt = evt; cts_evt = cts;
    #8;
    idx   = int'(addr[5:2]);
    sz_ok = (size == 2'd1);
    ad_ok = (addr[1:0] == 2'b00) && (idx < 12);
    hit   = sel && sz_ok && ad_ok;
    e_code = !sel ? 2'd0 : (!sz_ok ? 2'd1 : (!ad_ok ? 2'd2 : 2'd0));
    e_rd = 16'h0;
    if (hit && !we) begin
      case (idx)
        5:  e_rd = {8'h00, m_flag[4], live_temt, live_thre, m_flag[3:0], live_dr};
        6:  e_rd = {15'h0, m_scts};
        8, 9: e_rd = m_ier;
        10: e_rd = {8'h00, m_thr};
        11: e_rd = {8'h00, rx_data};
        default: e_rd = m_reg[idx];
      endcase
    end
    if (tag_in != "") tag = tag_in;
    else if (sel && !sz_ok) tag = "R2";
    else if (sel && !ad_ok) tag = "R3";
    else if (!hit) tag = "R13";
    else case (idx)
      5:  tag = we ? "R6" : "R9";
      6:  tag = "R7";
      8, 9: tag = we ? "R4" : "R5";
      10: tag = "R10";
      11: tag = we ? "R8" : "R11";
      default: tag = "R1";
    endcase
    chk(tag, "rdata", bus_rdata, e_rd);
    chk((e_code != 0) ? tag : "R13", "err", bus_err, (e_code != 2'd0));
    chk(tag, "err_code", bus_err_code, e_code);
    chk(tag, "tx_valid", tx_valid, hit && we && idx == 10);
    if (hit && we && idx == 10) chk("R10", "tx_data", tx_data, wd[7:0]);
    chk(tag, "tx_event", tx_event, hit && we && idx == 10 && m_ier[1]);
    chk(tag, "rx_pop", rx_pop, hit && !we && idx == 11);
    @(posedge clk);
    if (hit && we) begin
      case (idx)
        5:  m_flag = m_flag & ~{wd[7], wd[4], wd[3], wd[2], wd[1]};
        6:  if (wd[0]) m_scts = 1'b0;
        8:  m_ier = m_ier | wd;
        9:  m_ier = m_ier & ~wd;
        10: m_thr = wd[7:0];
        11: ;
        default: m_reg[idx] = wd;
      endcase
    end
    m_flag = m_flag | evt;
    if (cts) m_scts = 1'b1;
  endtask

  task automatic rd(input logic [5:0] a, input string t);
    step(1'b1, 1'b0, a, 2'd1, 16'h0, 5'h0, 1'b0, t);
  endtask
  task automatic wr(input logic [5:0] a, input logic [15:0] d, input string t);
    step(1'b1, 1'b1, a, 2'd1, d, 5'h0, 1'b0, t);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset values of every register
    for (int i = 0; i < 12; i++) if (i != 11) rd(6'(i * 4), "R12");

    // R1: plain registers with two patterns
    for (int i = 0; i < 8; i++) if (i != 5 && i != 6) wr(6'(i * 4), 16'hA5C3 ^ 16'(i * 16'h1111), "R1");
    for (int i = 0; i < 8; i++) if (i != 5 && i != 6) rd(6'(i * 4), "R1");
    for (int i = 0; i < 8; i++) if (i != 5 && i != 6) wr(6'(i * 4), ~(16'h0F0F << i), "R1");
    for (int i = 0; i < 8; i++) if (i != 5 && i != 6) rd(6'(i * 4), "R1");

    // R10: transmit with event gate off, then on right after enabling
    wr(6'h28, 16'hFF3C, "R10");
    rd(6'h28, "R10");
    wr(6'h20, 16'h0002, "R4");
    wr(6'h28, 16'h0081, "R10");
    // R4/R5: set and clear enables, read at both addresses
    wr(6'h20, 16'h8401, "R4");
    rd(6'h24, "R5");
    wr(6'h24, 16'h0403, "R4");
    rd(6'h20, "R5");
    wr(6'h28, 16'h0055, "R10");

    // R11 / R8: receive buffer reads and ignored write
    rx_data = 8'hC7; rd(6'h2C, "R11");
    rx_data = 8'h19; wr(6'h2C, 16'hFFFF, "R8");
    rd(6'h2C, "R11");

    // R9: live ready bits
    live_dr = 1'b1; live_thre = 1'b0; live_temt = 1'b0; rd(6'h14, "R9");
    live_dr = 1'b0; live_thre = 1'b1; live_temt = 1'b0; rd(6'h14, "R9");

    // R6: set all flags, write-one-to-clear, ready bits unwritable, collision
    step(1'b0, 1'b0, 6'h0, 2'd1, 16'h0, 5'h1F, 1'b0, "R6");
    rd(6'h14, "R6");
    wr(6'h14, 16'h0061, "R6");
    rd(6'h14, "R6");
    step(1'b1, 1'b1, 6'h14, 2'd1, 16'hFFFF, 5'h04, 1'b0, "R6");
    rd(6'h14, "R6");

    // R7: modem status set, collision, clear
    step(1'b1, 1'b1, 6'h18, 2'd1, 16'h0001, 5'h0, 1'b1, "R7");
    rd(6'h18, "R7");
    wr(6'h18, 16'hFFFE, "R7");
    rd(6'h18, "R7");
    wr(6'h18, 16'h0001, "R7");
    rd(6'h18, "R7");

    // R2 / R3: bad size outranks bad address; bad addresses leave state alone
    step(1'b1, 1'b1, 6'h30, 2'd0, 16'h1234, 5'h0, 1'b0, "R2");
    step(1'b1, 1'b0, 6'h1C, 2'd2, 16'h0, 5'h0, 1'b0, "R2");
    step(1'b1, 1'b1, 6'h1E, 2'd1, 16'hBEEF, 5'h0, 1'b0, "R3");
    step(1'b1, 1'b1, 6'h3C, 2'd1, 16'hBEEF, 5'h0, 1'b0, "R3");
    step(1'b1, 1'b1, 6'h1C, 2'd3, 16'hBEEF, 5'h0, 1'b0, "R2");
    rd(6'h1C, "R3");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [5:0] a;
      logic [1:0] sz;
      a  = 6'($urandom_range(0, 15) * 4);
      if ($urandom_range(0, 9) == 0) a = a + 6'd2;
      sz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
      rx_data   = 8'($urandom);
      live_dr   = 1'($urandom);
      live_thre = 1'($urandom);
      live_temt = 1'($urandom);
      step(1'($urandom_range(0, 4) != 0), 1'($urandom), a, sz, 16'($urandom),
           ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'h0,
           ($urandom_range(0, 7) == 0), "");
    end

    summary();
    $finish;
  end
endmodule